// File: doc/BRIEF.md
# Word-wide CRC32 residue checker

This block checks the integrity of a received packet, one 32-bit word per clock. A running CRC32 register absorbs every payload word and also the trailer word that holds the transmitted CRC. A correctly received packet always leaves the register at a fixed, nonzero good-packet residue. When a verify strobe arrives together with the trailer word, the block compares the register value, with that word already included, against the residue. It answers with a registered match pulse that lasts one cycle.

A packet starts with a one-cycle init strobe. The init strobe loads the register from the preload input, normally with all ones. Reception can also be interleaved. The surrounding logic saves a partial remainder when it switches to another packet. Later it restores that remainder through the same preload path and resumes the first packet where it stopped. Finding packet boundaries and handling the length field belong to the surrounding logic.

Top module: `crcResidueChecker`

## Requirements
- R1: While reset is held, and on the first cycle after reset is released, the match output is low.
- R2: Each word is absorbed into the register only on a cycle where data-valid is high. Absorption is MSB first: bit 31 is processed first, with the polynomial 0x04C11DB7 and no reflection. Cycles with data-valid low leave the register unchanged.
- R3: On a cycle where the init strobe is high, the register takes the preload value, and any word presented with data-valid on that cycle is discarded.
- R4: A verify strobe on the same cycle as an init strobe produces no match pulse.
- R5: When verify is sampled, the comparison uses the register value with that cycle's valid word already absorbed. The compare value is 0xC704DD7B. On a match, the output is high on the next cycle only.
- R6: The match output stays low on any cycle that follows a cycle without a verify strobe, whatever the register holds.
- R7: The check passes for a packet built as follows: the register starts at 0xFFFFFFFF, absorbs the payload words, and the bitwise inverse of the result is appended as the trailer. The check fails if any single bit of that packet is flipped.
- R8: Preloading a partial remainder saved from an earlier run resumes that packet exactly, even after other packets have used the register in between.
- R9: A verify strobe with data-valid low compares the register as it stands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all inputs are sampled on its rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| initStrobe | input | 1 | Loads the register from preloadValue |
| preloadValue | input | 32 | Start value or saved partial remainder |
| dataValid | input | 1 | Qualifies dataWord for absorption |
| dataWord | input | 32 | Packet word, bit 31 absorbed first |
| verifyStrobe | input | 1 | Requests the residue comparison this cycle |
| matchPulse | output | 1 | One-cycle pulse on a residue match |

## Verification
The bench builds the block with its default parameters: a 32-bit word, a 32-bit register, the 0x04C11DB7 polynomial and the 0xC704DD7B residue. With these values, packets can be encoded by a bit-serial model in the bench and checked end to end. The packets range from a trailer-only packet to a multi-word one. They exercise gaps in data-valid, init colliding with data or with verify, verify arriving late, single-bit corruption, and two packets interleaved through saved remainders.

// File: rtl/crcChkPkg.sv
package crcChkPkg;

  localparam int unsigned CRC_W       = 32;
  localparam int unsigned WORD_W      = 32;
  localparam logic [CRC_W-1:0] CRC_POLY    = 32'h04C1_1DB7;
  localparam logic [CRC_W-1:0] CRC_RESIDUE = 32'hC704_DD7B;

  // Strobes from the control to the datapath, one cycle each.
  typedef struct packed {
    logic loadEn;    // take the preload value
    logic absorbEn;  // fold the presented word into the register
    logic checkEn;   // compare the next register value to the residue
  } crcStrobes_t;

endpackage

// File: rtl/crcChkCtrl.sv
module crcChkCtrl
  import crcChkPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        initStrobe,
  input  logic        dataValid,
  input  logic        verifyStrobe,
  output crcStrobes_t strobes
);

  // Init wins over data and disables the check in its own cycle.
  always_comb begin
    strobes          = '0;
    strobes.loadEn   = initStrobe;
    strobes.absorbEn = dataValid && !initStrobe;
    strobes.checkEn  = verifyStrobe && !initStrobe;
  end

  AST_LOAD_ABSORB_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.loadEn, strobes.absorbEn})); // R3

  AST_CHECK_NEEDS_VERIFY: assert property (@(posedge clk) disable iff (!rstN)
    strobes.checkEn |-> verifyStrobe); // R6

endmodule

// File: rtl/crcChkDatapath.sv
module crcChkDatapath
  import crcChkPkg::*;
#(
  parameter int unsigned          DW      = WORD_W,
  parameter int unsigned          CW      = CRC_W,
  parameter logic [CRC_W-1:0]     POLY    = CRC_POLY,
  parameter logic [CRC_W-1:0]     RESIDUE = CRC_RESIDUE
) (
  input  logic          clk,
  input  logic          rstN,
  input  crcStrobes_t   strobes,
  input  logic [CW-1:0] preloadValue,
  input  logic [DW-1:0] dataWord,
  output logic          matchPulse
);

  localparam int unsigned TOP = CW - 1;

  logic [CW-1:0] crcReg;
  logic [CW-1:0] foldedVal;
  logic [CW-1:0] nextVal;
  logic          residueHit;

  // MSB-first fold of one whole word, unrolled across DW bits.
  function automatic logic [CW-1:0] foldWord(input logic [CW-1:0] start,
                                             input logic [DW-1:0] word);
    logic [CW-1:0] acc;
    logic          fb;
    acc = start;
    for (int b = DW - 1; b >= 0; b--) begin
      fb  = acc[TOP] ^ word[b];
      acc = {acc[CW-2:0], 1'b0};
      if (fb) acc = acc ^ POLY[CW-1:0];
    end
    return acc;
  endfunction

  assign foldedVal  = foldWord(crcReg, dataWord);
  assign nextVal    = strobes.absorbEn ? foldedVal : crcReg;
  assign residueHit = (nextVal == RESIDUE[CW-1:0]);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      crcReg <= '0;
    end else if (strobes.loadEn) begin
      crcReg <= preloadValue;
    end else if (strobes.absorbEn) begin
      crcReg <= foldedVal;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) matchPulse <= 1'b0;
    else       matchPulse <= strobes.checkEn && residueHit;
  end

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.loadEn && !strobes.absorbEn) |=> $stable(crcReg)); // R2

  AST_MATCH_FROM_CHECK: assert property (@(posedge clk) disable iff (!rstN)
    matchPulse |-> $past(strobes.checkEn)); // R5

  AST_LOAD_TAKES_PRELOAD: assert property (@(posedge clk) disable iff (!rstN)
    strobes.loadEn |=> (crcReg == $past(preloadValue))); // R3

endmodule

// File: rtl/crcResidueChecker.sv
module crcResidueChecker
  import crcChkPkg::*;
#(
  parameter int unsigned      DW      = WORD_W,
  parameter logic [CRC_W-1:0] POLY    = CRC_POLY,
  parameter logic [CRC_W-1:0] RESIDUE = CRC_RESIDUE
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             initStrobe,
  input  logic [CRC_W-1:0] preloadValue,
  input  logic             dataValid,
  input  logic [DW-1:0]    dataWord,
  input  logic             verifyStrobe,
  output logic             matchPulse
);

  crcStrobes_t strobes;

  crcChkCtrl i_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .initStrobe   (initStrobe),
    .dataValid    (dataValid),
    .verifyStrobe (verifyStrobe),
    .strobes      (strobes)
  );

  crcChkDatapath #(
    .DW      (DW),
    .CW      (CRC_W),
    .POLY    (POLY),
    .RESIDUE (RESIDUE)
  ) i_datapath (
    .clk          (clk),
    .rstN         (rstN),
    .strobes      (strobes),
    .preloadValue (preloadValue),
    .dataWord     (dataWord),
    .matchPulse   (matchPulse)
  );

  AST_NO_VERIFY_NO_MATCH: assert property (@(posedge clk) disable iff (!rstN)
    !verifyStrobe |=> !matchPulse); // R6

  AST_INIT_BLOCKS_MATCH: assert property (@(posedge clk) disable iff (!rstN)
    initStrobe |=> !matchPulse); // R4

  always_comb begin
    if (!rstN) AST_RESET_LOW: assert (!matchPulse); // R1
  end

endmodule

// File: tb/test_crcResidueChecker.sv
module test_crcResidueChecker;

  localparam logic [31:0] POLY = 32'h04C1_1DB7;
  localparam logic [31:0] GOOD = 32'hC704_DD7B;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        initStrobe = 1'b0;
  logic [31:0] preloadValue = '0;
  logic        dataValid = 1'b0;
  logic [31:0] dataWord = '0;
  logic        verifyStrobe = 1'b0;
  logic        matchPulse;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 1'b0;

  logic [31:0] pkt [0:15];
  int          pktLen;

  always #2 clk = ~clk;

  crcResidueChecker i_crcResidueChecker (
    .clk(clk), .rstN(rstN), .initStrobe(initStrobe), .preloadValue(preloadValue),
    .dataValid(dataValid), .dataWord(dataWord), .verifyStrobe(verifyStrobe),
    .matchPulse(matchPulse)
  );

  function automatic logic [31:0] refFold(input logic [31:0] c, input logic [31:0] d);
    for (int b = 31; b >= 0; b--) begin
      logic fb;
      fb = c[31] ^ d[b];
      c = c << 1;
      if (fb) c = c ^ POLY;
    end
    return c;
  endfunction

  // Builds payload of n words plus inverted-CRC trailer into pkt.
  task automatic buildPacket(input int n, input logic [31:0] seed);
    logic [31:0] c;
    c = 32'hFFFF_FFFF;
    for (int k = 0; k < n; k++) begin
      pkt[k] = seed ^ (32'h9E37_79B9 * (k + 1));
      c = refFold(c, pkt[k]);
    end
    pkt[n] = ~c;
    pktLen = n + 1;
  endtask

  task automatic check(input string req, input logic act, input logic exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s: matchPulse=%0b expected %0b", req, act, exp);
    end
  endtask

  // One clock: inputs held across a rising edge, then sampled at negedge.
  task automatic cycle(input logic ini, input logic [31:0] pre, input logic dv,
                       input logic [31:0] d, input logic ver);
    initStrobe = ini; preloadValue = pre; dataValid = dv; dataWord = d; verifyStrobe = ver;
    @(negedge clk);
    initStrobe = 0; dataValid = 0; verifyStrobe = 0;
  endtask

  task automatic sendPacket(input bit gaps, input bit doVerify, output logic seenMatch);
    seenMatch = 0;
    cycle(1, 32'hFFFF_FFFF, 0, '0, 0);
    for (int k = 0; k < pktLen; k++) begin
      if (gaps) cycle(0, 0, 0, 32'hDEAD_BEEF, 0);
      cycle(0, 0, 1, pkt[k], doVerify && (k == pktLen - 1));
      if (k < pktLen - 1 && matchPulse) seenMatch = 1;
    end
  endtask

  task automatic testReset();
    @(negedge clk);
    check("R1 during reset", matchPulse, 1'b0);
    rstN = 1;
    @(negedge clk);
    check("R1 after release", matchPulse, 1'b0);
  endtask

  task automatic testGood();
    logic early;
    buildPacket(5, 32'h1234_5678);
    sendPacket(0, 1, early);
    check("R5 match after trailer", matchPulse, 1'b1);
    check("R5 no early pulse", early, 1'b0);
    cycle(0, 0, 0, 0, 0);
    check("R5 pulse lasts one cycle", matchPulse, 1'b0);
    buildPacket(0, 32'h0);
    sendPacket(0, 1, early);
    check("R7 trailer-only packet", matchPulse, 1'b1);
  endtask

  task automatic testGaps();
    logic early;
    buildPacket(4, 32'hA5A5_0F0F);
    sendPacket(1, 1, early);
    check("R2 gaps ignored", matchPulse, 1'b1);
  endtask

  task automatic testCorrupt();
    logic early;
    buildPacket(6, 32'h0BAD_F00D);
    pkt[2] = pkt[2] ^ 32'h0000_0100;
    sendPacket(0, 1, early);
    check("R7 payload bit flip", matchPulse, 1'b0);
    buildPacket(3, 32'h7777_1111);
    pkt[3] = pkt[3] ^ 32'h8000_0000;
    sendPacket(0, 1, early);
    check("R7 trailer bit flip", matchPulse, 1'b0);
  endtask

  task automatic testNoVerify();
    logic early;
    buildPacket(3, 32'h5555_AAAA);
    sendPacket(0, 0, early);
    check("R6 no verify no pulse", matchPulse, 1'b0);
    cycle(0, 0, 0, 0, 1);
    check("R9 late verify on held register", matchPulse, 1'b1);
  endtask

  task automatic testInitPriority();
    buildPacket(3, 32'hC0DE_0001);
    cycle(1, 32'hFFFF_FFFF, 1, 32'h1357_9BDF, 0);
    for (int k = 0; k < pktLen; k++)
      cycle(0, 0, 1, pkt[k], k == pktLen - 1);
    check("R3 word with init discarded", matchPulse, 1'b1);
  endtask

  task automatic testInitVerify();
    // Preload the residue itself: a verify with init must still not match.
    cycle(1, GOOD, 0, 0, 1);
    check("R4 init blocks verify", matchPulse, 1'b0);
    cycle(0, 0, 0, 0, 1);
    check("R9 verify on loaded residue", matchPulse, 1'b1);
  endtask

  task automatic testInterleave();
    logic [31:0] pktA [0:15];
    logic [31:0] saveA;
    int lenA;
    buildPacket(6, 32'h2468_ACE0);
    for (int k = 0; k < pktLen; k++) pktA[k] = pkt[k];
    lenA = pktLen;
    saveA = 32'hFFFF_FFFF;
    cycle(1, 32'hFFFF_FFFF, 0, 0, 0);
    for (int k = 0; k < 3; k++) begin
      cycle(0, 0, 1, pktA[k], 0);
      saveA = refFold(saveA, pktA[k]);
    end
    buildPacket(2, 32'hFEED_0042);
    cycle(1, 32'hFFFF_FFFF, 0, 0, 0);
    for (int k = 0; k < pktLen; k++) cycle(0, 0, 1, pkt[k], k == pktLen - 1);
    check("R8 other packet in between", matchPulse, 1'b1);
    cycle(1, saveA, 0, 0, 0);
    for (int k = 3; k < lenA; k++) cycle(0, 0, 1, pktA[k], k == lenA - 1);
    check("R8 resumed packet matches", matchPulse, 1'b1);
  endtask

  initial begin
    #(4 * 200000);
    if (!finished) begin
      testsFailed++;
      $display("FAIL watchdog: run did not complete, actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    testReset();
    testGood();
    testGaps();
    testCorrupt();
    testNoVerify();
    testInitPriority();
    testInitVerify();
    testInterleave();
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule